// File: doc/BRIEF.md
# Two-Level Interrupt Vector Acknowledge Unit

This block pairs two eight-input interrupt controller cores, an upper (master) core and a lower (slave) core, and resolves a single CPU acknowledge strobe into an 8-bit interrupt vector. Request line n goes to core n>>3, input n&7. Input 2 of the master carries no external line. It is the cascade input, and it becomes pending whenever the slave holds an unserviced request. The master's pending state alone drives the CPU interrupt line.

On acknowledge, the master's highest-priority pending input is serviced. If that input is the cascade input, the slave's highest-priority pending input is serviced too, and the vector comes from the slave base. When a controller has nothing to offer, the vector falls back to that controller's base plus 7. Both vector bases are plain inputs. Each input is either edge-sensitive or level-sensitive, and the choice is fixed by a parameter.

The vector leaves as a one-beat stream with a valid strobe and no ready. The consumer must take the vector in the cycle the strobe is high, because the block applies no back-pressure. Acknowledge strobes may arrive on consecutive cycles, and each one yields its own vector.

Top module: `cascade_vector_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cpu_int` and `vec_valid` are 0 and `vec` is 0.
- R2: An edge-sensitive line n in 0..7 (n not 2) that rises makes `cpu_int` high one clock later.
- R3: Within the master, the lowest pending input index wins. With the default split, edge inputs are 0, 1 and 3 and level inputs are 4 to 7. A master win on input k≠2 gives `vec` = `master_base` + k.
- R4: A rising line n in 8..15 makes `cpu_int` high two clocks later. A master win on input 2 services the slave's lowest pending input j and gives `vec` = `slave_base` + j.
- R5: If the master wins on input 2 while the slave has nothing pending, `vec` = `slave_base` + 7. This happens when a level slave line drops after being serviced. The cascade input is then cleared.
- R6: An acknowledge while `cpu_int` is low gives `vec` = `master_base` + 7 and changes no pending state.
- R7: `vec_valid` is high for exactly the cycle after each cycle in which `int_ack` is high. `vec` holds its value when `int_ack` is low.
- R8: Servicing an edge input clears it. A line that stays high does not request again until it falls and rises.
- R9: A level input (default lines 4–7 and 12–15) is pending exactly while its line is high, and servicing does not clear it.
- R10: Request line 2 has no effect, because master input 2 is reserved for the cascade.
- R11: Vector sums wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines; bit n goes to core n>>3, input n&7 |
| int_ack | input | 1 | CPU acknowledge strobe, one vector per high cycle |
| master_base | input | 8 | Vector base for the master core |
| slave_base | input | 8 | Vector base for the slave core |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Acknowledged vector |
| vec_valid | output | 1 | Vector strobe, one cycle after `int_ack` |

## Verification
A stale pending bit shows up at the ports in one of two ways: `cpu_int` stays high after its line was serviced, or the next vector is wrong. Either is visible within one or two clocks of the acknowledge. A lost cascade bit shows as `cpu_int` failing to rise two clocks after a slave line. A cascade bit left set by mistake shows as a slave-spurious vector on the following acknowledge. Sweeping every line under several base pairs puts each input's index, edge or level mode and cascade path on the vector bus where its value is checked.

// File: rtl/cvu_pkg.sv
package cvu_pkg;
  localparam int unsigned CVU_CTRL_LINES = 8;
  localparam int unsigned CVU_VEC_W      = 8;
  localparam int unsigned CVU_CAS_INPUT  = 2;

  typedef enum logic [1:0] {
    SRC_MASTER  = 2'd0,
    SRC_SLAVE   = 2'd1,
    SRC_SPUR_M  = 2'd2,
    SRC_SPUR_S  = 2'd3
  } vec_src_e;
endpackage

// File: rtl/cvu_prio_pick.sv
module cvu_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cvu_intc_core.sv
module cvu_intc_core #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N),
  parameter logic [N-1:0] LEVEL = '0,
  parameter logic [N-1:0] LATCH = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          ack_i,
  output logic [N-1:0]  pend_o,
  output logic [IW-1:0] win_idx_o
);
  logic [N-1:0]  pend_q;
  logic [N-1:0]  pend_d;
  logic          win_vld;
  logic [IW-1:0] win_idx;

  cvu_prio_pick #(.N(N), .IW(IW)) u_pick (
    .req (pend_q),
    .vld (win_vld),
    .idx (win_idx)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (LATCH[i]) begin : g_latch
      logic hit;
      assign hit       = ack_i && win_vld && (win_idx == IW'(i));
      assign pend_d[i] = (pend_q[i] & ~hit) | req_i[i];
    end else if (LEVEL[i]) begin : g_level
      assign pend_d[i] = req_i[i];
    end else begin : g_edge
      logic hit;
      logic last_q;
      assign hit = ack_i && win_vld && (win_idx == IW'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= req_i[i];
      end
      assign pend_d[i] = (pend_q[i] & ~hit) | (req_i[i] & ~last_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o    = pend_q;
  assign win_idx_o = win_idx;
endmodule

// File: rtl/cascade_vector_unit.sv
module cascade_vector_unit
  import cvu_pkg::*;
#(
  parameter int unsigned CTRL_LINES = CVU_CTRL_LINES,
  parameter int unsigned VEC_W      = CVU_VEC_W,
  parameter int unsigned CAS_INPUT  = CVU_CAS_INPUT,
  parameter logic [2*CTRL_LINES-1:0] LEVEL_LINES = 16'hF0F0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*CTRL_LINES-1:0] irq_lines,
  input  logic                    int_ack,
  input  logic [VEC_W-1:0]        master_base,
  input  logic [VEC_W-1:0]        slave_base,
  output logic                    cpu_int,
  output logic [VEC_W-1:0]        vec,
  output logic                    vec_valid
);
  localparam int unsigned N     = CTRL_LINES;
  localparam int unsigned IDX_W = $clog2(N);
  localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] CAS_BIT  = ONE_HOT0 << CAS_INPUT;
  localparam logic [N-1:0] M_LEVEL  = LEVEL_LINES[N-1:0] & ~CAS_BIT;
  localparam logic [N-1:0] S_LEVEL  = LEVEL_LINES[2*N-1:N];
  localparam logic [VEC_W-1:0] SPUR_OFS = VEC_W'(N - 1);

  logic [N-1:0]     m_req, m_pend, s_pend, s_clr;
  logic [IDX_W-1:0] m_idx, s_idx;
  logic             m_any, s_any, m_on_cas, s_ack, s_rem_any;
  vec_src_e         src;
  logic [VEC_W-1:0] vec_d;
  logic [VEC_W-1:0] vec_q;
  logic             vld_q;

  assign m_any    = |m_pend;
  assign s_any    = |s_pend;
  assign m_on_cas = m_any && (m_idx == IDX_W'(CAS_INPUT));
  assign s_ack    = int_ack && m_on_cas;

  // Slave requests that survive this cycle's service keep the cascade input set.
  assign s_clr     = (s_ack && s_any) ? ((ONE_HOT0 << s_idx) & ~S_LEVEL) : '0;
  assign s_rem_any = |(s_pend & ~s_clr);

  // External line at the cascade position is discarded.
  assign m_req = (irq_lines[N-1:0] & ~CAS_BIT) | (s_rem_any ? CAS_BIT : '0);

  cvu_intc_core #(.N(N), .IW(IDX_W), .LEVEL(M_LEVEL), .LATCH(CAS_BIT)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (m_req),
    .ack_i     (int_ack),
    .pend_o    (m_pend),
    .win_idx_o (m_idx)
  );

  cvu_intc_core #(.N(N), .IW(IDX_W), .LEVEL(S_LEVEL), .LATCH('0)) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (irq_lines[2*N-1:N]),
    .ack_i     (s_ack),
    .pend_o    (s_pend),
    .win_idx_o (s_idx)
  );

  always_comb begin
    if (!m_any)        src = SRC_SPUR_M;
    else if (m_on_cas) src = s_any ? SRC_SLAVE : SRC_SPUR_S;
    else               src = SRC_MASTER;
  end

  always_comb begin
    unique case (src)
      SRC_MASTER: vec_d = master_base + VEC_W'(m_idx);
      SRC_SLAVE:  vec_d = slave_base + VEC_W'(s_idx);
      SRC_SPUR_S: vec_d = slave_base + SPUR_OFS;
      default:    vec_d = master_base + SPUR_OFS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= int_ack;
      if (int_ack) vec_q <= vec_d;
    end
  end

  assign cpu_int   = m_any;
  assign vec       = vec_q;
  assign vec_valid = vld_q;
endmodule

// File: rtl/cascade_vector_unit_chk.sv
module cascade_vector_unit_chk #(
  parameter int unsigned CTRL_LINES = 8,
  parameter int unsigned VEC_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_ack,
  input logic [VEC_W-1:0] master_base,
  input logic             cpu_int,
  input logic [VEC_W-1:0] vec,
  input logic             vec_valid
);
  localparam logic [VEC_W-1:0] SPUR_OFS = VEC_W'(CTRL_LINES - 1);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!vec_valid && !cpu_int));

  assert_ack_gives_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> vec_valid);

  assert_no_ack_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |=> !vec_valid);

  assert_vec_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |=> $stable(vec));

  assert_idle_ack_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !cpu_int) |=> (vec == $past(master_base + SPUR_OFS)));
endmodule

bind cascade_vector_unit cascade_vector_unit_chk #(
  .CTRL_LINES (CTRL_LINES),
  .VEC_W      (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_ack     (int_ack),
  .master_base (master_base),
  .cpu_int     (cpu_int),
  .vec         (vec),
  .vec_valid   (vec_valid)
);

// File: tb/cascade_vector_unit_tb.sv
`timescale 1ns/1ps
module cascade_vector_unit_tb;
  localparam logic [15:0] LVL = 16'hF0F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        ack = 1'b0;
  logic [7:0]  mb = 8'h20;
  logic [7:0]  sb = 8'h28;
  logic        cpu_int;
  logic [7:0]  vec;
  logic        vec_valid;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cascade_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq), .int_ack(ack),
    .master_base(mb), .slave_base(sb),
    .cpu_int(cpu_int), .vec(vec), .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_vec(input string req, input logic [7:0] exp);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk({req, " valid"}, vec_valid, 1);
    chk({req, " vector"}, vec, exp);
  endtask

  function automatic string wrap_tag(input logic [7:0] base, input int ofs, input string dflt);
    return (int'(base) + ofs > 255) ? "R11" : dflt;
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 cpu_int in reset", cpu_int, 0);
    chk("R1 vec_valid in reset", vec_valid, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 cpu_int after reset", cpu_int, 0);
    chk("R1 vec_valid after reset", vec_valid, 0);
    chk("R1 vec after reset", vec, 0);

    // R10: line 2 is ignored
    irq[2] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R10 line 2 no request", cpu_int, 0);
    end
    expect_vec("R10", mb + 8'd7);
    irq[2] = 1'b0;
    step(1);

    // R6: idle acknowledge
    expect_vec("R6 idle", mb + 8'd7);
    chk("R6 idle no request", cpu_int, 0);
    step(1);
    chk("R7 strobe drops", vec_valid, 0);
    chk("R7 vec holds", vec, mb + 8'd7);

    // R6: ack while slave pending but cascade not yet visible
    irq[10] = 1'b1;
    step(1);
    chk("R6 cpu_int still low", cpu_int, 0);
    expect_vec("R6 slave untouched", mb + 8'd7);
    chk("R6 cascade arrives", cpu_int, 1);
    expect_vec("R6 slave then served", sb + 8'd2);
    chk("R8 slave edge cleared", cpu_int, 0);
    irq[10] = 1'b0;
    step(1);

    // R3: master priority
    irq[1] = 1'b1; irq[3] = 1'b1;
    step(1);
    expect_vec("R3 lowest first", mb + 8'd1);
    chk("R3 second pending", cpu_int, 1);
    expect_vec("R3 next", mb + 8'd3);
    chk("R3 drained", cpu_int, 0);
    irq[1] = 1'b0; irq[3] = 1'b0;
    step(1);

    // R3/R4: cascade input beats input 3
    irq[3] = 1'b1; irq[9] = 1'b1;
    step(2);
    expect_vec("R3 cascade beats 3", sb + 8'd1);
    expect_vec("R3 then master 3", mb + 8'd3);
    chk("R3 drained", cpu_int, 0);
    irq[3] = 1'b0; irq[9] = 1'b0;
    step(1);

    // R4: slave priority, cascade kept while slave has more
    irq[11] = 1'b1; irq[9] = 1'b1;
    step(2);
    expect_vec("R4 slave lowest", sb + 8'd1);
    chk("R4 cascade kept", cpu_int, 1);
    expect_vec("R4 slave next", sb + 8'd3);
    chk("R4 drained", cpu_int, 0);
    irq[11] = 1'b0; irq[9] = 1'b0;
    step(1);

    // R7: back-to-back acknowledges
    irq[0] = 1'b1; irq[1] = 1'b1;
    step(1);
    ack = 1'b1;
    step(1);
    chk("R7 b2b valid 1", vec_valid, 1);
    chk("R7 b2b vec 1", vec, mb + 8'd0);
    step(1);
    ack = 1'b0;
    chk("R7 b2b valid 2", vec_valid, 1);
    chk("R7 b2b vec 2", vec, mb + 8'd1);
    step(1);
    chk("R7 b2b strobe drops", vec_valid, 0);

    // R8: held edge line does not retrigger until it toggles
    irq[1] = 1'b0;
    step(3);
    chk("R8 held high no rerequest", cpu_int, 0);
    irq[0] = 1'b0;
    step(1);
    irq[0] = 1'b1;
    step(1);
    chk("R8 retrigger", cpu_int, 1);
    expect_vec("R8 retrigger vec", mb + 8'd0);
    irq[0] = 1'b0;
    step(1);

    // Sweep all lines under several base pairs
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: begin mb = 8'h20; sb = 8'h28; end
        1: begin mb = 8'h08; sb = 8'h70; end
        default: begin mb = 8'hFC; sb = 8'hFA; end
      endcase
      for (int n = 0; n < 16; n++) begin
        if (n == 2) continue;
        irq[n] = 1'b1;
        step(1);
        if (n < 8) begin
          chk("R2 master line one clock", cpu_int, 1);
          expect_vec(wrap_tag(mb, n, "R3"), mb + 8'(n));
        end else begin
          chk("R4 slave line not yet", cpu_int, 0);
          step(1);
          chk("R4 slave line two clocks", cpu_int, 1);
          expect_vec(wrap_tag(sb, n - 8, "R4"), sb + 8'(n - 8));
        end
        if (LVL[n]) chk("R9 level stays pending", cpu_int, 1);
        else        chk("R8 edge cleared", cpu_int, 0);
        step(2);
        chk("R7 no strobe", vec_valid, 0);
        if (LVL[n]) chk("R9 level held", cpu_int, 1);
        else        chk("R8 edge held no rerequest", cpu_int, 0);
        irq[n] = 1'b0;
        step(1);
        if (LVL[n] && n >= 8) begin
          chk("R5 cascade latched", cpu_int, 1);
          expect_vec(wrap_tag(sb, 7, "R5"), sb + 8'd7);
          chk("R5 cascade cleared", cpu_int, 0);
        end else begin
          chk("R9 released", cpu_int, 0);
        end
        step(1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule